// File: doc/BRIEF.md
# Mesh Route Computation with South-Last Wireless Shortcuts

This unit picks the output port for a flit header at one router of a two-dimensional mesh. It takes the router's own coordinate, the destination coordinate, and the port the flit arrived on. It also takes a flag telling whether this router carries a diagonal wireless shortcut, and the coordinate at the far end of that link. It returns a one-hot choice among north, south, east, west, local and wireless. The choice is registered, so it appears one clock after the inputs are presented. X grows toward east and Y grows toward north.

A router without a shortcut uses dimension-ordered routing: X is resolved first, then Y. A router with a shortcut applies a south-last turn model. A flit already travelling south may not turn. A flit travelling west may not reverse to east. The wireless port is taken only when it is legal under these rules and strictly shortens the remaining Manhattan distance. This keeps the shortcut free of deadlock cycles.

When a hybrid router gets a flit that no legal turn can serve, it selects no port at all. That case cannot occur in traffic that obeys the turn model.

Top module: `sl_route_unit`

## Requirements
- R1: While rst_ni is low, port_o is all zeros.
- R2: port_o reflects the inputs sampled at the previous rising clock edge and holds steady between edges.
- R3: When the destination equals the current coordinate, port_o selects local (bit 0), on any router and for any arrival port.
- R4: With wl_present_i low, port_o follows XY routing and ignores in_dir_i. It selects east (bit 3) if dst_x > cur_x, else west (bit 4) if dst_x < cur_x, else north (bit 1) if dst_y > cur_y, else south (bit 2). On a hybrid router, the same XY choice is the default whenever no other rule applies.
- R5: With wl_present_i high, the wireless port (bit 5) is selected when the Manhattan distance from the far end to the destination is strictly smaller than the distance from here, and the turn rules allow it.
- R6: The wireless port is never selected for a flit that arrived on the wireless port (in_dir_i = 5), or when the far end equals the current coordinate.
- R7: A wireless link whose far end lies south of the current row is used only if, after it, the remaining path is purely southward or ends there (far_x = dst_x and dst_y <= far_y).
- R8: On a hybrid router, a flit arriving on the north port (in_dir_i = 1, travelling south) gets only south or local. If XY would pick any other port, no port is selected, and the wireless port is never chosen.
- R9: On a hybrid router, a flit arriving on the east port (in_dir_i = 3, travelling west) never gets east. That case yields no port.
- R10: At most one bit of port_o is set. in_dir_i codes are: 0 local, 1 north port, 2 south port, 3 east port, 4 west port, 5 wireless; 6 and 7 are treated like local.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_x_i | input | XW | X coordinate of this router |
| cur_y_i | input | YW | Y coordinate of this router |
| dst_x_i | input | XW | Destination X coordinate |
| dst_y_i | input | YW | Destination Y coordinate |
| in_dir_i | input | 3 | Port the flit arrived on |
| wl_present_i | input | 1 | This router has a wireless shortcut |
| wl_far_x_i | input | XW | X coordinate of the shortcut's far end |
| wl_far_y_i | input | YW | Y coordinate of the shortcut's far end |
| port_o | output | 6 | One-hot output port: 0 local, 1 N, 2 S, 3 E, 4 W, 5 wireless |

## Verification
The bench builds the unit as a 4x4 mesh, so XW and YW are both 2. With that size, random coordinates often land on equal X or Y values, on mesh edges, and on far ends that sit exactly at the destination or in its column. This exercises the strict-shortening compare, the southward-tail exception and the suppressed-turn cases far more often than a large mesh would. Directed cases pin down each rule with hand-picked coordinates. Thousands of random headers mix base and hybrid routers with all eight arrival codes.

// File: rtl/sl_route_pkg.sv
package sl_route_pkg;
  localparam int PORTS = 6;
  localparam int P_LOCAL = 0;
  localparam int P_N = 1;
  localparam int P_S = 2;
  localparam int P_E = 3;
  localparam int P_W = 4;
  localparam int P_WL = 5;

  typedef logic [PORTS-1:0] port_vec_t;

  // arrival port codes
  localparam logic [2:0] FROM_LOCAL = 3'd0;
  localparam logic [2:0] FROM_N     = 3'd1;
  localparam logic [2:0] FROM_S     = 3'd2;
  localparam logic [2:0] FROM_E     = 3'd3;
  localparam logic [2:0] FROM_W     = 3'd4;
  localparam logic [2:0] FROM_WL    = 3'd5;
endpackage

// File: rtl/sl_xy_port.sv
module sl_xy_port
  import sl_route_pkg::*;
#(
  parameter int XW = 3,
  parameter int YW = 3
) (
  input  logic [XW-1:0] cur_x_i,
  input  logic [YW-1:0] cur_y_i,
  input  logic [XW-1:0] dst_x_i,
  input  logic [YW-1:0] dst_y_i,
  output port_vec_t     port_o
);
  always_comb begin
    port_o = '0;
    if (dst_x_i > cur_x_i)      port_o[P_E] = 1'b1;
    else if (dst_x_i < cur_x_i) port_o[P_W] = 1'b1;
    else if (dst_y_i > cur_y_i) port_o[P_N] = 1'b1;
    else if (dst_y_i < cur_y_i) port_o[P_S] = 1'b1;
    else                        port_o[P_LOCAL] = 1'b1;
  end
endmodule

// File: rtl/sl_wl_check.sv
module sl_wl_check
  import sl_route_pkg::*;
#(
  parameter int XW = 3,
  parameter int YW = 3
) (
  input  logic [XW-1:0] cur_x_i,
  input  logic [YW-1:0] cur_y_i,
  input  logic [XW-1:0] dst_x_i,
  input  logic [YW-1:0] dst_y_i,
  input  logic [2:0]    in_dir_i,
  input  logic          wl_present_i,
  input  logic [XW-1:0] far_x_i,
  input  logic [YW-1:0] far_y_i,
  output logic          wl_ok_o
);
  localparam int DW = ((XW > YW) ? XW : YW) + 2;

  logic [DW-1:0] dist_cur, dist_far;
  logic          shorter, far_south, tail_ok, far_is_cur, dir_ok;

  always_comb begin
    dist_cur = ((dst_x_i >= cur_x_i) ? DW'(dst_x_i - cur_x_i) : DW'(cur_x_i - dst_x_i))
             + ((dst_y_i >= cur_y_i) ? DW'(dst_y_i - cur_y_i) : DW'(cur_y_i - dst_y_i));
    dist_far = ((dst_x_i >= far_x_i) ? DW'(dst_x_i - far_x_i) : DW'(far_x_i - dst_x_i))
             + ((dst_y_i >= far_y_i) ? DW'(dst_y_i - far_y_i) : DW'(far_y_i - dst_y_i));
  end

  assign shorter    = dist_far < dist_cur;
  assign far_south  = far_y_i < cur_y_i;
  // a southward hop is legal only as the final leg
  assign tail_ok    = (far_x_i == dst_x_i) && (dst_y_i <= far_y_i);
  assign far_is_cur = (far_x_i == cur_x_i) && (far_y_i == cur_y_i);
  assign dir_ok     = (in_dir_i != FROM_WL) && (in_dir_i != FROM_N);

  assign wl_ok_o = wl_present_i && dir_ok && !far_is_cur && shorter
                   && (!far_south || tail_ok);
endmodule

// File: rtl/sl_route_unit.sv
module sl_route_unit
  import sl_route_pkg::*;
#(
  parameter int MESH_X = 8,
  parameter int MESH_Y = 8,
  localparam int XW = (MESH_X > 2) ? $clog2(MESH_X) : 1,
  localparam int YW = (MESH_Y > 2) ? $clog2(MESH_Y) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [XW-1:0] cur_x_i,
  input  logic [YW-1:0] cur_y_i,
  input  logic [XW-1:0] dst_x_i,
  input  logic [YW-1:0] dst_y_i,
  input  logic [2:0]    in_dir_i,
  input  logic          wl_present_i,
  input  logic [XW-1:0] wl_far_x_i,
  input  logic [YW-1:0] wl_far_y_i,
  output logic [5:0]    port_o
);
  port_vec_t xy_port, route_d, port_q;
  logic      wl_ok, at_dest;

  sl_xy_port #(.XW(XW), .YW(YW)) u_xy (
    .cur_x_i(cur_x_i), .cur_y_i(cur_y_i),
    .dst_x_i(dst_x_i), .dst_y_i(dst_y_i),
    .port_o (xy_port)
  );

  sl_wl_check #(.XW(XW), .YW(YW)) u_wl (
    .cur_x_i(cur_x_i), .cur_y_i(cur_y_i),
    .dst_x_i(dst_x_i), .dst_y_i(dst_y_i),
    .in_dir_i(in_dir_i), .wl_present_i(wl_present_i),
    .far_x_i(wl_far_x_i), .far_y_i(wl_far_y_i),
    .wl_ok_o(wl_ok)
  );

  assign at_dest = (cur_x_i == dst_x_i) && (cur_y_i == dst_y_i);

  always_comb begin
    route_d = xy_port;
    if (at_dest) begin
      route_d = '0;
      route_d[P_LOCAL] = 1'b1;
    end else if (wl_present_i) begin
      if (wl_ok) begin
        route_d = '0;
        route_d[P_WL] = 1'b1;
      end else if (in_dir_i == FROM_N) begin
        // travelling south: no turn allowed
        if (!xy_port[P_S]) route_d = '0;
      end else if (in_dir_i == FROM_E) begin
        // travelling west: no reversal
        if (xy_port[P_E]) route_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) port_q <= '0;
    else         port_q <= route_d;
  end

  assign port_o = port_q;

  // R10
  onehot_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(port_o));

  // R3
  dest_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_x_i == dst_x_i && cur_y_i == dst_y_i) |=> (port_o == 6'b000001));

  // R4
  base_no_wl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wl_present_i |=> !port_o[P_WL]);

  // R8
  south_no_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wl_present_i && in_dir_i == FROM_N) |=>
      (!port_o[P_E] && !port_o[P_W] && !port_o[P_N] && !port_o[P_WL]));

  // R9
  west_no_reverse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wl_present_i && in_dir_i == FROM_E) |=> !port_o[P_E]);

  // R6
  wl_no_rearrive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_dir_i == FROM_WL) |=> !port_o[P_WL]);
endmodule

// File: tb/sl_route_unit_tb.sv
module sl_route_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] cur_x, cur_y, dst_x, dst_y, far_x, far_y;
  logic [2:0] in_dir;
  logic       wl_present;
  logic [5:0] port_o;

  int checks = 0;
  int failures = 0;
  logic [5:0] prev_exp;
  bit prev_valid = 0;

  always #2 clk = ~clk;

  sl_route_unit #(.MESH_X(4), .MESH_Y(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .cur_x_i(cur_x), .cur_y_i(cur_y), .dst_x_i(dst_x), .dst_y_i(dst_y),
    .in_dir_i(in_dir), .wl_present_i(wl_present),
    .wl_far_x_i(far_x), .wl_far_y_i(far_y), .port_o(port_o)
  );

  function automatic int absdiff(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic void model(input int cx, cy, dx, dy, dir, wp, fx, fy,
                                output logic [5:0] e, output string tag);
    logic [5:0] xyv;
    int dc, df;
    bit south, tail, farcur, base_ok;
    if (dx > cx) xyv = 6'b001000;
    else if (dx < cx) xyv = 6'b010000;
    else if (dy > cy) xyv = 6'b000010;
    else if (dy < cy) xyv = 6'b000100;
    else xyv = 6'b000001;
    if (cx == dx && cy == dy) begin e = 6'b000001; tag = "R3"; return; end
    if (wp == 0) begin e = xyv; tag = "R4"; return; end
    dc = absdiff(cx, dx) + absdiff(cy, dy);
    df = absdiff(fx, dx) + absdiff(fy, dy);
    south = fy < cy;
    tail = (fx == dx) && (dy <= fy);
    farcur = (fx == cx) && (fy == cy);
    base_ok = (df < dc) && (dir != 1);
    if (dir != 5 && !farcur && base_ok && (!south || tail)) begin
      e = 6'b100000; tag = "R5"; return;
    end
    if (dir == 1) begin
      e = xyv[2] ? xyv : 6'b0; tag = "R8";
    end else if (dir == 3 && xyv[3]) begin
      e = 6'b0; tag = "R9";
    end else begin
      e = xyv;
      if (dir == 5 || farcur) tag = "R6";
      else if (base_ok && south && !tail) tag = "R7";
      else tag = "R5";
    end
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s port_o actual=%b expected=%b (cur=%0d,%0d dst=%0d,%0d dir=%0d wl=%0b far=%0d,%0d)",
               tag, act, exp, cur_x, cur_y, dst_x, dst_y, in_dir, wl_present, far_x, far_y);
    end
  endtask

  task automatic apply(input int cx, cy, dx, dy, dir, wp, fx, fy);
    logic [5:0] e;
    string tag;
    @(negedge clk);
    cur_x = 2'(cx); cur_y = 2'(cy); dst_x = 2'(dx); dst_y = 2'(dy);
    in_dir = 3'(dir); wl_present = wp[0]; far_x = 2'(fx); far_y = 2'(fy);
    #1;
    if (prev_valid) check("R2", port_o, prev_exp);
    model(cx, cy, dx, dy, dir, wp, fx, fy, e, tag);
    @(negedge clk);
    check(tag, port_o, e);
    checks++;
    if ($countones(port_o) > 1) begin
      failures++;
      $display("FAIL R10 ones actual=%0d expected<=1", $countones(port_o));
    end
    prev_exp = e;
    prev_valid = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5a17;
    void'($urandom(seed));
    cur_x = 0; cur_y = 0; dst_x = 3; dst_y = 3; in_dir = 0;
    wl_present = 1; far_x = 3; far_y = 3;
    repeat (3) @(negedge clk);
    check("R1", port_o, 6'b0);
    rst_ni = 1'b1;

    // R3 destination reached
    apply(1, 1, 1, 1, 1, 1, 3, 3);
    apply(2, 0, 2, 0, 5, 0, 0, 0);
    // R4 base XY, arrival port ignored
    apply(0, 0, 3, 2, 0, 0, 3, 3);
    apply(2, 3, 2, 0, 1, 0, 0, 0);
    apply(1, 1, 3, 1, 3, 0, 0, 0);
    apply(3, 1, 3, 2, 2, 0, 0, 0);
    // R5 shortcut strictly shorter
    apply(0, 0, 3, 2, 0, 1, 3, 3);
    apply(0, 0, 0, 3, 0, 1, 1, 1);
    // R6 no re-entry, far end equal to current
    apply(0, 0, 3, 2, 5, 1, 3, 3);
    apply(0, 0, 3, 2, 0, 1, 0, 0);
    // R7 southward link only as a tail
    apply(0, 3, 3, 0, 0, 1, 3, 0);
    apply(0, 3, 2, 0, 0, 1, 3, 0);
    // R8 travelling south
    apply(1, 2, 1, 0, 1, 1, 1, 0);
    apply(1, 2, 2, 0, 1, 1, 2, 0);
    // R9 travelling west
    apply(1, 1, 3, 1, 3, 1, 0, 0);
    apply(2, 1, 0, 1, 3, 1, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      apply($urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4,
            $urandom % 8, $urandom % 2, $urandom % 4, $urandom % 4);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule